// File: doc/BRIEF.md
# Split Binary Counter

This block is a four-bit counter built from two separately advanced sections. A one-bit section toggles on each falling edge of count input `count_a`. A three-bit section advances on each falling edge of count input `count_b`. Both count inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer and a falling-edge detector. The detector produces a single-cycle advance enable for its section.

A clear forces every output bit to zero without waiting for a clock edge. The clear acts only while both `clr_a` and `clr_b` are high, and while it acts it overrides both count inputs.

The sections can be joined outside the block. Feeding `q[0]` back into `count_b` turns the block into a modulo-16 binary counter driven from `count_a`. Used alone, `count_b` drives a three-bit divider on `q[3:1]`, and the low bit remains free for other use. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `split_cnt_top`

## Requirements
- R1: After the system reset `rst_n` is released, `q` is 4'b0000.
- R2: `q[0]` inverts once for each high-to-low transition of `count_a`. The change is visible no later than the third rising `clk` edge after the transition. A low-to-high transition of `count_a` leaves `q` unchanged.
- R3: `q[3:1]` increases by one, as a 3-bit value, for each high-to-low transition of `count_b`. It wraps from 3'b111 to 3'b000, and there is no terminal-count output.
- R4: The sections are independent. `count_a` never changes `q[3:1]`, and `count_b` never changes `q[0]`.
- R5: While `clr_a` and `clr_b` are both high, `q` is 4'b0000. This takes effect asynchronously, with no `clk` edge required.
- R6: While the clear of R5 is held, transitions on the count inputs do not change `q`.
- R7: If only one of `clr_a` and `clr_b` is high, both sections count exactly as when neither is high.
- R8: With `count_b` driven from `q[0]` outside the block, successive falling edges on `count_a` step `q` through the binary sequence 0 to 15 and then back to 0. `q[0]` is the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low asynchronous system reset; clears the synchronizers and both sections |
| count_a | input | 1 | Asynchronous count input of the one-bit section; acts on its falling edge |
| count_b | input | 1 | Asynchronous count input of the three-bit section; acts on its falling edge |
| clr_a | input | 1 | First clear input; a clear needs both clear inputs high |
| clr_b | input | 1 | Second clear input |
| q | output | 4 | Counter state; bit 0 is the one-bit section, bits 3:1 are the three-bit section |

## Verification
Some properties are checked on every clock cycle. The first is that `q` reads zero whenever both clear inputs are high. The others tie each section to its own detected edge: a detected edge makes the section step by exactly one, and with no detected edge the section holds its value.

Other behaviours can only be shown by the bench's scenarios. These are the full modulo-16 sequence when the sections are joined outside the block, and the wrap of the three-bit section. They also include the fact that a single clear input has no effect, that the clear acts before any clock edge, and that rising edges on the count inputs are ignored.

// File: rtl/split_cnt_pkg.sv
package split_cnt_pkg;
  localparam int unsigned LO_W     = 1;
  localparam int unsigned HI_W     = 3;
  localparam int unsigned CNT_W    = LO_W + HI_W;
  localparam int unsigned N_CNT_IN = 2;
  localparam int unsigned SEC_LO   = 0;
  localparam int unsigned SEC_HI   = 1;
endpackage

// File: rtl/split_cnt_fall_det.sv
// Synchronizes an asynchronous count input and flags its falling edge
// with a single-cycle pulse on the system clock.
module split_cnt_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/split_cnt_stage.sv
// One counting section: advances by one on each enable pulse and is
// cleared asynchronously.
module split_cnt_stage #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         adv,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q <= '0;
    end else if (adv) begin
      q <= q + W'(1);
    end
  end
endmodule

// File: rtl/split_cnt_top.sv
module split_cnt_top
  import split_cnt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_a,
  input  logic             count_b,
  input  logic             clr_a,
  input  logic             clr_b,
  output logic [CNT_W-1:0] q
);
  logic [N_CNT_IN-1:0] cnt_in;
  logic [N_CNT_IN-1:0] fall;
  logic                clr_hit;
  logic                stage_arst_n;

  assign cnt_in = {count_b, count_a};

  // One synchronizer and edge detector for each count input
  for (genvar gi = 0; gi < N_CNT_IN; gi++) begin : g_edge
    split_cnt_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cnt_in[gi]),
      .fall (fall[gi])
    );
  end

  // The clear acts only when both inputs are high (R5, R7)
  assign clr_hit      = clr_a & clr_b;
  assign stage_arst_n = rst_n & ~clr_hit;

  split_cnt_stage #(.W(LO_W)) u_lo (
    .clk   (clk),
    .arst_n(stage_arst_n),
    .adv   (fall[SEC_LO]),
    .q     (q[LO_W-1:0])
  );

  split_cnt_stage #(.W(HI_W)) u_hi (
    .clk   (clk),
    .arst_n(stage_arst_n),
    .adv   (fall[SEC_HI]),
    .q     (q[CNT_W-1:LO_W])
  );
endmodule

// File: rtl/split_cnt_chk.sv
module split_cnt_chk #(
  parameter int unsigned LO_W  = 1,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_a,
  input logic             clr_b,
  input logic [CNT_W-1:0] q,
  input logic [1:0]       fall
);
  logic clr_now;
  assign clr_now = clr_a & clr_b;

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |-> (q == '0));

  a_r2_lo_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[0] && !clr_now) |=> ((q[0] != $past(q[0])) || clr_now));

  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall[0] |=> ($stable(q[LO_W-1:0]) || clr_now));

  a_r3_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[1] && !clr_now) |=>
      ((q[CNT_W-1:LO_W] == ($past(q[CNT_W-1:LO_W]) + 1'b1)) || clr_now));

  a_r4_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall[1] |=> ($stable(q[CNT_W-1:LO_W]) || clr_now));
endmodule

bind split_cnt_top split_cnt_chk #(.LO_W(split_cnt_pkg::LO_W), .CNT_W(split_cnt_pkg::CNT_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .clr_a(clr_a),
  .clr_b(clr_b),
  .q    (q),
  .fall (fall)
);

// File: tb/split_cnt_top_tb.sv
module split_cnt_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_a = 1'b0;
  logic       tb_b = 1'b0;
  logic       tie = 1'b1;
  logic       clr_a = 1'b0;
  logic       clr_b = 1'b0;
  logic [3:0] q;
  logic       count_b;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  // Vectors for the unjoined mode: {pulses on a, pulses on b, expected q}
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {4'd1, 4'd0, 4'b0001},
    {4'd1, 4'd0, 4'b0000},
    {4'd0, 4'd3, 4'b0110},
    {4'd1, 4'd5, 4'b0001},
    {4'd0, 4'd7, 4'b1111},
    {4'd0, 4'd1, 4'b0001}
  };

  always #4 clk = ~clk;

  assign count_b = tie ? q[0] : tb_b;

  split_cnt_top u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .count_a(tb_a),
    .count_b(count_b),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .q      (q)
  );

  task automatic check(input string rid, input logic [3:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s q=%b expected %b", rid, q, exp);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk) tb_a = 1'b1;
    repeat (4) @(negedge clk);
    tb_a = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) tb_b = 1'b1;
    repeat (4) @(negedge clk);
    tb_b = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset", 4'b0000);

    // R8: joined mode, 40 pulses against a modulo-16 reference
    for (int i = 1; i <= 40; i++) begin
      pulse_a();
      check("R8 joined count", 4'(i % 16));
    end

    // R2: a rising edge alone leaves q unchanged
    @(negedge clk) tb_a = 1'b1;
    repeat (8) @(negedge clk);
    check("R2 rising edge ignored", 4'd8);
    tb_a = 1'b0;
    repeat (8) @(negedge clk);
    check("R2 falling edge counts", 4'd9);

    // R7: one clear input alone does not stop counting
    @(negedge clk) clr_a = 1'b1;
    pulse_a();
    check("R7 clr_a alone", 4'd10);
    @(negedge clk) clr_a = 1'b0; clr_b = 1'b1;
    pulse_a();
    check("R7 clr_b alone", 4'd11);
    @(negedge clk) clr_b = 1'b0;

    // R5: clear in the middle of the count, visible before any clock edge
    @(negedge clk);
    clr_a = 1'b1;
    clr_b = 1'b1;
    #1;
    check("R5 asynchronous clear", 4'b0000);

    // R6: counting inputs have no effect while the clear is held
    pulse_a();
    check("R6 clear overrides count", 4'b0000);
    pulse_a();
    check("R6 clear overrides count", 4'b0000);
    @(negedge clk) clr_a = 1'b0; clr_b = 1'b0;
    repeat (8) @(negedge clk);
    check("R5 after clear release", 4'b0000);

    // R3 R4: unjoined mode, table of pulse counts
    @(negedge clk) tie = 1'b0;
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][11:8]); k++) pulse_a();
      for (int k = 0; k < int'(VEC[v][7:4]); k++) pulse_b();
      check("R3 R4 independent sections", VEC[v][3:0]);
    end

    // R4: count_b alone never touches the low bit
    pulse_b();
    check("R4 low bit untouched", 4'b0011);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule